// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a three-wire serial EEPROM with 16-bit words. Chip select, serial clock and serial data-in arrive from an external master. They are resynchronised to the system clock, and the serial clock's rising edges are found by edge detection. Each frame starts with a 1, followed by a two-bit command code and an address, all sent most significant bit first. The block then reads out words, stores a word, or switches write permission on or off.

Reads begin with a single zero placeholder bit. Then the addressed word follows, and successive words continue for as long as the serial clock keeps running, wrapping from the last address back to zero. A store starts when chip select falls after a complete write frame. It then occupies a self-timed interval of a parameter-set number of system clocks. While that interval runs, raising chip select turns the data output into a busy/ready flag.

The data output comes with a separate drive-enable, so the pad's tri-state buffer sits outside the block.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, the drive-enable output is 0 and writing is not permitted.
- R2: A frame of 1, command code 10 and the address turns the drive-enable on after the last address bit. The block first presents one 0 bit, then the addressed 16-bit word, most significant bit first.
- R3: During a read, the data output changes only in response to a rising edge of the serial clock.
- R4: While chip select stays high and the serial clock keeps toggling, the next word follows at once with no placeholder bit, and the address after the highest one is 0.
- R5: A frame of 1, command code 01, the address and 16 data bits stores the word when chip select then falls. The new word fully replaces the old one, with no erase needed first, and the store interval begins in the following clock.
- R6: Command code 00 with the two top address bits 11 permits writes, and with 00 forbids them. A write frame received while writes are forbidden leaves the memory unchanged.
- R7: A write is performed only when the program-enable input is 1. The permit and forbid commands take effect whatever that input's level.
- R8: A store keeps the block busy for STORE_CYCLES system clocks. Raising chip select during that time drives the output to 0 while busy and to 1 once the store is complete. Serial input in this status phase is ignored.
- R9: Chip select low turns the drive-enable off within one clock of the synchronised level. A write frame cut short by chip select falling stores nothing and starts no busy interval.
- R10: Zero bits clocked in before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select from the master, active high |
| sk_i | input | 1 | Serial clock from the master |
| di_i | input | 1 | Serial data from the master |
| pgm_en_i | input | 1 | Program enable; must be 1 for a write to happen |
| do_o | output | 1 | Serial data / status output |
| do_oe_o | output | 1 | Drive-enable for the data output pad |

## Verification
The bench places a word with its top bit set at a read address. A design that forgot the placeholder bit, or repeated it on later words, would then misread every bit. A sequential read starting two words below the top of the address space checks that the address wraps to zero, rather than stalling or running off the end. Writes are attempted with permission off and with program-enable low, and a write frame is cut after half its data. Any of these that leaked into the memory shows up as a changed word on a later read. Status polling during a store checks that the output is 0 first and then turns to 1, and that a read frame sent during polling is not decoded.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_WDATA,
    ST_WWAIT,
    ST_SKIP,
    ST_STAT
  } mw_state_e;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] MISC_PERMIT = 2'b11;
  localparam logic [1:0] MISC_FORBID = 2'b00;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end

endmodule

// File: rtl/mw_store_timer.sv
module mw_store_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (start)         left_q <= CW'(CYCLES);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int STORE_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic pgm_en_i,
  output logic do_o,
  output logic do_oe_o
);
  import mw_pkg::*;

  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(((HDR_W > DATA_W) ? HDR_W : DATA_W) + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

  logic cs_s, sk_s, di_s, sk_d, sk_rise;
  logic busy;
  logic mem_we;
  logic [DATA_W-1:0] rdata;

  mw_state_e         st_q;
  logic [HDR_W-1:0]  hdr_q, hdr_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rsh_q;
  logic              wen_q;
  logic [1:0]        op_nx, top_nx;

  mw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_i, sk_i, di_i}),
    .q   ({cs_s, sk_s, di_s})
  );

  mw_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (wd_q),
    .raddr (addr_q),
    .rdata (rdata)
  );

  mw_store_timer #(.CYCLES(STORE_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (mem_we),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) sk_d <= 1'b0;
    else     sk_d <= sk_s;
  end

  assign sk_rise = sk_s & ~sk_d;

  always_comb begin
    hdr_nx = {hdr_q[HDR_W-2:0], di_s};
    op_nx  = hdr_nx[HDR_W-1 -: 2];
    top_nx = hdr_nx[ADDR_W-1 -: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      hdr_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      rsh_q   <= '0;
      wen_q   <= 1'b0;
      mem_we  <= 1'b0;
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (!cs_s) begin
        if (st_q == ST_WWAIT && wen_q && pgm_en_i) mem_we <= 1'b1;
        st_q    <= ST_IDLE;
        cnt_q   <= '0;
        do_o    <= 1'b0;
        do_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (busy) begin
              st_q    <= ST_STAT;
              do_oe_o <= 1'b1;
              do_o    <= 1'b0;
            end else if (sk_rise && di_s) begin
              st_q  <= ST_CMD;
              cnt_q <= '0;
            end
          end
          ST_CMD: begin
            if (sk_rise) begin
              hdr_q <= hdr_nx;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == HDR_LAST) begin
                addr_q <= hdr_nx[ADDR_W-1:0];
                cnt_q  <= '0;
                case (op_nx)
                  OP_READ: begin
                    st_q    <= ST_READ;
                    do_oe_o <= 1'b1;
                    do_o    <= 1'b0;
                  end
                  OP_WRITE: st_q <= ST_WDATA;
                  OP_MISC: begin
                    if (top_nx == MISC_PERMIT)      wen_q <= 1'b1;
                    else if (top_nx == MISC_FORBID) wen_q <= 1'b0;
                    st_q <= ST_SKIP;
                  end
                  default: st_q <= ST_SKIP;
                endcase
              end
            end
          end
          ST_READ: begin
            if (sk_rise) begin
              if (cnt_q == '0) begin
                do_o  <= rdata[DATA_W-1];
                rsh_q <= {rdata[DATA_W-2:0], 1'b0};
              end else begin
                do_o  <= rsh_q[DATA_W-1];
                rsh_q <= {rsh_q[DATA_W-2:0], 1'b0};
              end
              if (cnt_q == DAT_LAST) begin
                cnt_q  <= '0;
                addr_q <= addr_q + 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_WDATA: begin
            if (sk_rise) begin
              wd_q  <= {wd_q[DATA_W-2:0], di_s};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == DAT_LAST) st_q <= ST_WWAIT;
            end
          end
          ST_STAT: begin
            do_oe_o <= 1'b1;
            do_o    <= ~busy;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      cs_s,
  input logic      sk_rise,
  input mw_state_e st_q,
  input logic      do_o,
  input logic      do_oe_o,
  input logic      mem_we,
  input logic      busy,
  input logic      wen_q,
  input logic      pgm_en_i
);

  AST_PLACEHOLDER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($rose(do_oe_o) && st_q == ST_READ) |-> !do_o); // R2

  AST_OUT_ON_SK_EDGE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_READ && $past(st_q) == ST_READ && !$past(sk_rise)) |-> $stable(do_o)); // R3

  AST_STORE_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> busy); // R5

  AST_STORE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wen_q)); // R6

  AST_STORE_NEEDS_PGM: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(pgm_en_i)); // R7

  AST_NO_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mem_we); // R8

  AST_CS_LOW_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !do_oe_o); // R9

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_s     (cs_s),
  .sk_rise  (sk_rise),
  .st_q     (st_q),
  .do_o     (do_o),
  .do_oe_o  (do_oe_o),
  .mem_we   (mem_we),
  .busy     (busy),
  .wen_q    (wen_q),
  .pgm_en_i (pgm_en_i)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int AW         = 6;
  localparam int STORE      = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, pgm = 1'b1;
  logic do_o, do_oe_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .DATA_W(16), .STORE_CYCLES(STORE), .SYNC_STAGES(2)) i_mw_eeprom (
    .clk      (clk),
    .rst      (rst),
    .cs_i     (cs),
    .sk_i     (sk),
    .di_i     (di),
    .pgm_en_i (pgm),
    .do_o     (do_o),
    .do_oe_o  (do_oe_o)
  );

  // [23:22] kind (1 = write, 2 = read and compare), [21:16] address, [15:0] word
  localparam logic [23:0] VEC [8] = '{
    {2'd1, 6'd3,  16'hBEEF},
    {2'd1, 6'd10, 16'h1234},
    {2'd2, 6'd3,  16'hBEEF},
    {2'd1, 6'd3,  16'h00FF},
    {2'd2, 6'd3,  16'h00FF},
    {2'd2, 6'd10, 16'h1234},
    {2'd1, 6'd63, 16'h8001},
    {2'd2, 6'd63, 16'h8001}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    repeat (HALF) @(negedge clk);
    sk = 1'b1;
    repeat (HALF) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [AW-1:0] a);
    cs = 1'b1;
    repeat (4) @(negedge clk);
    sk_bit(1'b1);
    sk_bit(op[1]);
    sk_bit(op[0]);
    for (int i = AW-1; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic drop_cs();
    cs = 1'b0;
    di = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) sk_bit(d[i]);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    frame(2'b01, a);
    send_word(d, 16);
    drop_cs();
    repeat (STORE + 10) @(negedge clk);
  endtask

  task automatic rd_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      sk_bit(1'b0);
      w[i] = do_o;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] w);
    frame(2'b10, a);
    rd_word(w);
    drop_cs();
  endtask

  task automatic misc(input logic [1:0] top);
    frame(2'b00, {top, {(AW-2){1'b0}}});
    drop_cs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, w2, w3;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 drive-enable after reset", {15'd0, do_oe_o}, 16'd0);

    // R6: writes forbidden after reset and after the forbid command
    wr(6'd5, 16'h1111);
    misc(2'b11);
    wr(6'd5, 16'hA5A5);
    misc(2'b00);
    wr(6'd5, 16'hFFFF);
    rd(6'd5, w);
    check("R6 write while forbidden ignored", w, 16'hA5A5);
    misc(2'b11);

    // table walk: R2 reads and R5 writes with overwrite
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][23:22] == 2'd1) wr(VEC[k][21:16], VEC[k][15:0]);
      else begin
        rd(VEC[k][21:16], w);
        check("R5 R2 table word", w, VEC[k][15:0]);
      end
    end

    // R2: placeholder zero, then top bit 1 of 8001
    frame(2'b10, 6'd63);
    check("R2 drive-enable after address", {15'd0, do_oe_o}, 16'd1);
    check("R2 placeholder bit", {15'd0, do_o}, 16'd0);
    rd_word(w);
    check("R2 word after placeholder", w, 16'h8001);
    drop_cs();

    // R7: program-enable gating
    pgm = 1'b0;
    wr(6'd10, 16'hFFFF);
    pgm = 1'b1;
    rd(6'd10, w);
    check("R7 write with pgm low ignored", w, 16'h1234);
    pgm = 1'b0;
    misc(2'b00);
    pgm = 1'b1;
    wr(6'd10, 16'h0000);
    rd(6'd10, w);
    check("R7 forbid acts with pgm low", w, 16'h1234);
    pgm = 1'b0;
    misc(2'b11);
    pgm = 1'b1;
    wr(6'd10, 16'h4321);
    rd(6'd10, w);
    check("R7 permit acts with pgm low", w, 16'h4321);

    // R4: sequential read across the top address
    wr(6'd62, 16'hC3C3);
    wr(6'd63, 16'h9009);
    wr(6'd0,  16'h7E01);
    frame(2'b10, 6'd62);
    rd_word(w);
    rd_word(w2);
    rd_word(w3);
    drop_cs();
    check("R4 first word", w, 16'hC3C3);
    check("R4 second word no placeholder", w2, 16'h9009);
    check("R4 wrap to address 0", w3, 16'h7E01);

    // R3: output holds while serial clock is idle mid-read
    frame(2'b10, 6'd3);
    sk_bit(1'b0);
    w[0] = do_o;
    repeat (40) @(negedge clk);
    check("R3 output stable without SK edge", {15'd0, do_o}, {15'd0, w[0]});
    drop_cs();

    // R8: status polling during a store
    frame(2'b01, 6'd20);
    send_word(16'h5555, 16);
    cs = 1'b0;
    repeat (6) @(negedge clk);
    cs = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 busy drive-enable", {15'd0, do_oe_o}, 16'd1);
    check("R8 busy reads 0", {15'd0, do_o}, 16'd0);
    repeat (STORE + 10) @(negedge clk);
    check("R8 ready reads 1", {15'd0, do_o}, 16'd1);
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0);
    for (int i = 0; i < AW; i++) sk_bit(1'b0);
    sk_bit(1'b0);
    check("R8 frame during status ignored", {15'd0, do_o}, 16'd1);
    drop_cs();
    rd(6'd20, w);
    check("R8 stored word", w, 16'h5555);

    // R9: aborts
    frame(2'b10, 6'd20);
    sk_bit(1'b0); sk_bit(1'b0);
    cs = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 drive-enable off after CS low", {15'd0, do_oe_o}, 16'd0);
    repeat (2) @(negedge clk);
    frame(2'b01, 6'd20);
    send_word(16'h00AA, 8);
    drop_cs();
    cs = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 no busy after cut write", {15'd0, do_oe_o}, 16'd0);
    drop_cs();
    rd(6'd20, w);
    check("R9 cut write stores nothing", w, 16'h5555);

    // R10: leading zeros before the start bit
    cs = 1'b1;
    repeat (4) @(negedge clk);
    sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b0);
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0);
    for (int i = AW-1; i >= 0; i--) sk_bit(((6'd10 >> i) & 6'd1) != 6'd0);
    rd_word(w);
    drop_cs();
    check("R10 leading zeros ignored", w, 16'h4321);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule